// File: doc/BRIEF.md
# Two-Input Fixed-Point Neuron with Table-Driven Tanh Activation

The block is one artificial neuron for small inference datapaths. Each clock it accepts two signed 8-bit data values, a signed 8-bit weight for each of them and a signed 8-bit bias. It forms the weighted sum in a wide accumulator, clips that sum to the signed 8-bit range and uses the clipped value as the address of a 256-entry read-only table. The table holds a tanh-shaped curve, and its word is the neuron output. The table contents are computed when the design is elaborated, from a rational approximation of tanh.

The datapath is a free-running three-stage pipeline: multiply, then add and clip, then table read. It has no backpressure. A new set of operands can enter on every clock, and `out_valid` reports which output cycles carry a result. The weights and the bias are ordinary input ports, so the same hardware can serve any trained neuron, with the weights loaded from outside. All arithmetic is two's complement, with bit 7 as the sign bit.

Top module: `neuron_tanh`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next cycle shows `out_valid` = 0 and `y` = 0.
- R2: `out_valid` equals the value that `in_valid` had three rising edges earlier. There is no other delay or gap.
- R3: The weighted sum is s = in_a*wt_a + in_b*wt_b + bias, formed exactly in 18 signed bits. The output for an operand set is act(clip(s)).
- R4: clip(s) is 127 for s > 127, -128 for s < -128, and s otherwise. So the all-+127 operands give `y` = 63, and both the -32640 and +32895 extremes are clipped.
- R5: For a clipped value c with magnitude m = |c|, the output magnitude is min(63, floor(2*m*(27648+m*m)/(27648+9*m*m))). The output takes the sign of c, so negative sums give negative two's-complement outputs.
- R6: The activation is odd: act(-c) = -act(c) for c in -127..127, and act(0) = 0.
- R7: The output is bounded to -63..+63, where 63 stands for +1.0. It is monotonically non-decreasing in the clipped sum over -128..127.
- R8: Operand sets presented on consecutive cycles each produce their own correct result on consecutive output cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on this cycle are a real sample |
| in_a | input | 8 | First data value, signed |
| wt_a | input | 8 | Weight for the first data value, signed |
| in_b | input | 8 | Second data value, signed |
| wt_b | input | 8 | Weight for the second data value, signed |
| bias | input | 8 | Bias term, signed |
| out_valid | output | 1 | `y` carries the result of the operands from three cycles earlier |
| y | output | 8 | Activated neuron output, signed, 63 = +1.0 |

## Verification
The bench targets the clipping boundaries. Sums of exactly 127, 128, -128 and -129 are driven, and so are the product extremes. A design that wraps instead of clipping would return a large output of the wrong sign there. A sweep of every clipped value from -128 to 127 compares each pair of mirrored outputs and checks the ordering across the sweep. A lost sign bit or a wrong table offset shows up as asymmetric or non-monotonic results. Back-to-back random operands with random gaps in `in_valid` expose latency errors, or results that end up on the wrong output cycle.

// File: rtl/neuron_pkg.sv
package neuron_pkg;
    localparam int DATA_W    = 8;
    localparam int PROD_W    = 2 * DATA_W;
    localparam int ACC_W     = PROD_W + 2;
    localparam int LUT_DEPTH = 1 << DATA_W;
    localparam int LUT_HALF  = LUT_DEPTH / 2;
    localparam int OUT_MAX   = 63;
    localparam int IN_SCALE  = 32;
    localparam int PADE_K    = 27 * IN_SCALE * IN_SCALE;
    localparam int LATENCY   = 3;

    // Table word for a clipped sum c: tanh(c/32) scaled by 64, clamped to 63, odd symmetric.
    function automatic logic [DATA_W-1:0] tanh_entry(input int c);
        int m;
        int mag;
        int val;
        m   = (c < 0) ? -c : c;
        mag = (2 * m * (PADE_K + m * m)) / (PADE_K + 9 * m * m);
        if (mag > OUT_MAX) mag = OUT_MAX;
        val = (c < 0) ? -mag : mag;
        return val[DATA_W-1:0];
    endfunction
endpackage

// File: rtl/neuron_mult_stage.sv
module neuron_mult_stage
    import neuron_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] wt_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [DATA_W-1:0] wt_b,
    input  logic [DATA_W-1:0] bias,
    output logic              prod_valid,
    output logic [PROD_W-1:0] prod_a,
    output logic [PROD_W-1:0] prod_b,
    output logic [DATA_W-1:0] bias_out
);
    typedef struct packed {
        logic              vld;
        logic [PROD_W-1:0] pa;
        logic [PROD_W-1:0] pb;
        logic [DATA_W-1:0] bs;
    } mult_st_t;

    mult_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        // Sign-extend to full product width; the low half of the product is exact.
        st_d.pa  = {{DATA_W{in_a[DATA_W-1]}}, in_a} * {{DATA_W{wt_a[DATA_W-1]}}, wt_a};
        st_d.pb  = {{DATA_W{in_b[DATA_W-1]}}, in_b} * {{DATA_W{wt_b[DATA_W-1]}}, wt_b};
        st_d.bs  = bias;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign prod_valid = st_q.vld;
    assign prod_a     = st_q.pa;
    assign prod_b     = st_q.pb;
    assign bias_out   = st_q.bs;
endmodule

// File: rtl/neuron_sum_clip.sv
module neuron_sum_clip
    import neuron_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              prod_valid,
    input  logic [PROD_W-1:0] prod_a,
    input  logic [PROD_W-1:0] prod_b,
    input  logic [DATA_W-1:0] bias_in,
    output logic              addr_valid,
    output logic [DATA_W-1:0] lut_addr
);
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'(LUT_HALF - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = -ACC_W'(LUT_HALF);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] addr;
    } sum_st_t;

    sum_st_t           st_d, st_q;
    logic [ACC_W-1:0]  acc;
    logic [DATA_W-1:0] clipped;

    always_comb begin
        acc = {{(ACC_W-PROD_W){prod_a[PROD_W-1]}}, prod_a}
            + {{(ACC_W-PROD_W){prod_b[PROD_W-1]}}, prod_b}
            + {{(ACC_W-DATA_W){bias_in[DATA_W-1]}}, bias_in};
        if ($signed(acc) > SAT_HI)      clipped = SAT_HI[DATA_W-1:0];
        else if ($signed(acc) < SAT_LO) clipped = SAT_LO[DATA_W-1:0];
        else                            clipped = acc[DATA_W-1:0];
        st_d      = st_q;
        st_d.vld  = prod_valid;
        // Offset binary: invert the sign so address 0 holds the most negative sum.
        st_d.addr = {~clipped[DATA_W-1], clipped[DATA_W-2:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.vld  <= 1'b0;
            st_q.addr <= DATA_W'(LUT_HALF);
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_valid = st_q.vld;
    assign lut_addr   = st_q.addr;
endmodule

// File: rtl/neuron_act_lut.sv
module neuron_act_lut
    import neuron_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_valid,
    input  logic [DATA_W-1:0] lut_addr,
    output logic              out_valid,
    output logic [DATA_W-1:0] y
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] word;
    } lut_st_t;

    lut_st_t           st_d, st_q;
    logic [DATA_W-1:0] table_w [LUT_DEPTH];

    for (genvar a = 0; a < LUT_DEPTH; a++) begin : g_rom
        assign table_w[a] = tanh_entry(a - LUT_HALF);
    end

    always_comb begin
        st_d      = st_q;
        st_d.vld  = addr_valid;
        st_d.word = table_w[lut_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign y         = st_q.word;
endmodule

// File: rtl/neuron_tanh.sv
module neuron_tanh
    import neuron_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] wt_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic [DATA_W-1:0] wt_b,
    input  logic [DATA_W-1:0] bias,
    output logic              out_valid,
    output logic [DATA_W-1:0] y
);
    logic              prod_valid;
    logic [PROD_W-1:0] prod_a;
    logic [PROD_W-1:0] prod_b;
    logic [DATA_W-1:0] bias_s1;
    logic              addr_valid;
    logic [DATA_W-1:0] lut_addr;

    neuron_mult_stage u_mult (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_a       (in_a),
        .wt_a       (wt_a),
        .in_b       (in_b),
        .wt_b       (wt_b),
        .bias       (bias),
        .prod_valid (prod_valid),
        .prod_a     (prod_a),
        .prod_b     (prod_b),
        .bias_out   (bias_s1)
    );

    neuron_sum_clip u_sum (
        .clk        (clk),
        .rst        (rst),
        .prod_valid (prod_valid),
        .prod_a     (prod_a),
        .prod_b     (prod_b),
        .bias_in    (bias_s1),
        .addr_valid (addr_valid),
        .lut_addr   (lut_addr)
    );

    neuron_act_lut u_lut (
        .clk        (clk),
        .rst        (rst),
        .addr_valid (addr_valid),
        .lut_addr   (lut_addr),
        .out_valid  (out_valid),
        .y          (y)
    );
endmodule

// File: rtl/neuron_tanh_chk.sv
module neuron_tanh_chk
    import neuron_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_a,
    input logic [DATA_W-1:0] wt_a,
    input logic [DATA_W-1:0] in_b,
    input logic [DATA_W-1:0] wt_b,
    input logic [DATA_W-1:0] bias,
    input logic              out_valid,
    input logic [DATA_W-1:0] y
);
    logic [1:0] cyc;
    logic       zero_in;
    logic       max_in;

    always_ff @(posedge clk) begin
        if (rst)            cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    assign zero_in = in_valid && (bias == '0) && ((in_a == '0) || (wt_a == '0))
                     && ((in_b == '0) || (wt_b == '0));
    assign max_in  = in_valid && (in_a == 8'd127) && (wt_a == 8'd127)
                     && (in_b == 8'd127) && (wt_b == 8'd127) && (bias == 8'd127);

    // R1
    a_r1_reset_clears: assert property (@(posedge clk) rst |=> (!out_valid && y == '0));

    // R2
    a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R7
    a_r7_bounded: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($signed(y) <= 8'sd63 && $signed(y) >= -8'sd63));

    // R6
    a_r6_zero_maps_zero: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd3 && $past(zero_in, 3)) |-> (out_valid && y == '0));

    // R4
    a_r4_clip_high: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd3 && $past(max_in, 3)) |-> (out_valid && y == 8'd63));
endmodule

bind neuron_tanh neuron_tanh_chk u_chk (.*);

// File: tb/tb_neuron_tanh.sv
module tb_neuron_tanh;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_a = '0, wt_a = '0, in_b = '0, wt_b = '0, bias = '0;
    logic       out_valid;
    logic [7:0] y;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // expected-result pipeline, index 2 is due at the current sample
    bit ev [3];
    int ey [3];
    int etag [3];
    int obs [256];

    always #4 clk = ~clk;

    neuron_tanh dut (.*);

    function automatic int clip8(input int s);
        if (s > 127) return 127;
        if (s < -128) return -128;
        return s;
    endfunction

    function automatic int act(input int c);
        int m, q;
        m = (c < 0) ? -c : c;
        q = (2 * m * (27648 + m * m)) / (27648 + 9 * m * m);
        if (q > 63) q = 63;
        return (c < 0) ? -q : q;
    endfunction

    task automatic chk(input string req, input int act_v, input int exp_v);
        checks++;
        if (act_v != exp_v) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    // One cycle at the falling edge: compare due result, then apply new operands.
    task automatic step(input bit v, input int a, input int wa, input int b, input int wb,
                        input int bs, input int tag, input string req);
        int s;
        @(negedge clk);
        chk("R2 out_valid", int'(out_valid), int'(ev[2]));
        if (ev[2]) begin
            chk(req, int'($signed(y)), ey[2]);
            if (etag[2] >= 0) obs[etag[2]] = int'($signed(y));
        end
        ev[2] = ev[1]; ey[2] = ey[1]; etag[2] = etag[1];
        ev[1] = ev[0]; ey[1] = ey[0]; etag[1] = etag[0];
        s = a * wa + b * wb + bs;
        ev[0] = v; ey[0] = act(clip8(s)); etag[0] = tag;
        in_valid = v;
        in_a = 8'(a); wt_a = 8'(wa); in_b = 8'(b); wt_b = 8'(wb); bias = 8'(bs);
    endtask

    task automatic flush();
        for (int i = 0; i < 4; i++) step(1'b0, 0, 0, 0, 0, 0, -1, "R3 flush");
    endtask

    initial begin
        int seed;
        seed = 32'h1d5a;
        void'($urandom(seed));
        for (int i = 0; i < 3; i++) begin ev[i] = 0; ey[i] = 0; etag[i] = -1; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        chk("R1 y in reset", int'(y), 0);
        rst = 1'b0;

        // R3 basic sums
        step(1, 3, 4, -2, 5, 1, -1, "R3 small sum");
        step(1, 10, -3, 7, 2, -5, -1, "R3 mixed signs");
        step(1, 0, 0, 0, 0, 0, -1, "R6 zero sum");
        // R4 clipping boundaries
        step(1, 127, 1, 0, 0, 0, -1, "R4 sum 127");
        step(1, 127, 1, 1, 1, 0, -1, "R4 sum 128");
        step(1, -128, 1, 0, 0, 0, -1, "R4 sum -128");
        step(1, -128, 1, -1, 1, 0, -1, "R4 sum -129");
        step(1, 127, 127, 127, 127, 127, -1, "R4 all +127");
        step(1, -128, -128, -128, -128, 127, -1, "R4 max positive");
        step(1, -128, 127, 127, -128, -128, -1, "R4 max negative");
        // R5 negative outputs keep sign
        step(1, -20, 3, 0, 0, 0, -1, "R5 negative -60");
        step(1, 0, 0, 5, -1, 0, -1, "R5 negative -5");
        flush();

        // R6/R7 sweep of every clipped value, back to back (R8)
        for (int c = -128; c < 128; c++) step(1, c, 1, 0, 0, 0, c + 128, "R8 sweep");
        flush();
        chk("R6 act(0)", obs[128], 0);
        for (int c = 1; c < 128; c++) chk("R6 odd symmetry", obs[128 - c], -obs[128 + c]);
        for (int c = 1; c < 256; c++) chk("R7 monotonic", int'(obs[c] >= obs[c - 1]), 1);
        chk("R7 top bound", obs[255], 63);
        chk("R7 bottom bound", obs[0], -63);

        // R8 random traffic with gaps
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(3, 0));
            step(r != 0, $signed(8'($urandom)), $signed(8'($urandom)),
                 $signed(8'($urandom)), $signed(8'($urandom)),
                 $signed(8'($urandom)), -1, "R3 random");
        end
        flush();

        // R1 reset mid-stream
        step(1, 50, 2, 0, 0, 0, -1, "R3 pre-reset");
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 mid reset valid", int'(out_valid), 0);
        chk("R1 mid reset y", int'(y), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule